// File: doc/BRIEF.md
# Search Co-processor Request Bus Serializer

This block turns one host command into a short train of words on the 72-bit request bus of a ternary-search co-processor. The block is clocked at the bus rate, so each of its clock cycles is one bus cycle. The host offers a command with a valid/ready handshake. The command carries an operation code, a width code, a payload of up to 288 bits, a device number, an access type, the mask and result register selectors, a direct/indirect flag and a 20-bit address.

Lookups place the key straight onto the bus with no address word. Every other operation first sends a formatted address word. Only the operations that carry data then send data slices. Wide values are cut into 72-bit slices and sent most-significant slice first. Alongside each word the block gives a valid strobe, a flag marking an address word, a flag marking the final word, and the entry offset of the current slice. A new command may be accepted in the same cycle in which the previous command's final word is on the bus, so commands can follow each other without a gap.

Top module: `sbreq_serializer`

## Requirements
- R1: After reset, `cmd_ready` is 1, `req_valid` is 0 and `req_bus` is all zero.
- R2: While no command is active, `req_valid`, `req_is_addr`, `req_last` and `req_offset` are 0 and `req_bus` is all zero, whatever values the command inputs hold.
- R3: A lookup (op 0) with width code 0 (72 bits) drives payload bits 71:0 for two consecutive cycles, both with offset 0, with no address word. `req_last` is set on the second cycle.
- R4: A lookup with width code 1 (144 bits) sends payload 143:72 and then 71:0. With width code 2 (288 bits) it sends 287:216, 215:144, 143:72 and then 71:0. The offsets count 0, 1, 2 and so on.
- R5: For data/mask read (op 1) and data/mask write (op 2), the address word has bits 71:34 at zero, device ID on 33:26, access type on 25:24, mask selector on 23:22, the indirect flag on 21, result selector on 20:17, address bit 14 on 16, address bit 13 on both 15 and 14, address 12:0 on 13:1, and bit 0 at zero.
- R6: For register read (op 3) and register write (op 4), the address word has device ID on 33:26, access type on 25:24 and address 7:0 on 7:0. All other bits are zero.
- R7: For SRAM read (op 5), SRAM write (op 6) and no-wait read (op 7), the address word has device ID on 33:26, access type on 25:24, bits 23:21 at zero, address 19:15 on 20:16, address bit 14 on both 15 and 14, and address 13:0 on 13:0.
- R8: A data/mask write sends its address word with `req_is_addr` high. It then sends the data slices most-significant first, in the same order and with the same offsets as a lookup of the same width.
- R9: The read ops (1, 3, 5, 7) send only the address word, which is also marked last. Register and SRAM writes send the address word and then one slice of payload 71:0 at offset 0, whatever the width code.
- R10: `cmd_ready` is low on every active cycle except the final word of a command. A command accepted on that final cycle starts on the very next cycle, so no idle cycle falls between the two commands.
- R11: `req_last` is high on exactly the final word of each command, and the bus returns to idle after it unless a new command was accepted.
- R12: Width code 3 is treated as width code 0 (72 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_op | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| cmd_width | input | 2 | Width code: 0 = 72, 1 = 144, 2 = 288, 3 = 72 |
| cmd_payload | input | 288 | Lookup key or write data |
| cmd_dev_id | input | 8 | Target device number |
| cmd_access | input | 2 | Access type field |
| cmd_mask_sel | input | 2 | Mask register selector |
| cmd_indirect | input | 1 | 0 = direct, 1 = indirect access |
| cmd_result_sel | input | 4 | Search-result register selector |
| cmd_addr | input | 20 | Entry, register or SRAM address |
| req_bus | output | 72 | Request bus word |
| req_valid | output | 1 | A word is on the bus |
| req_is_addr | output | 1 | The current word is an address word |
| req_last | output | 1 | The current word is the command's final word |
| req_offset | output | 2 | Entry offset of the current data slice |

## Verification
On every cycle, the assertions check the following: the bus is zero when idle, reserved address bits are zero, the duplicated address bit agrees on bus bits 15 and 14, ready stays low before the final word, and the bus goes idle after the final word unless a new command was accepted. Only the bench's scenarios can show the ordering of the slices, their offsets, the exact field placement for each operation class, the treatment of width code 3, and the gap-free chaining of two commands. These checks need the payload and fields that were sent.

// File: rtl/sbreq_pkg.sv
package sbreq_pkg;

    localparam int SLICE_W     = 72;
    localparam int MAX_SLICES  = 4;
    localparam int PAYLOAD_W   = SLICE_W * MAX_SLICES;
    localparam int SIDX_W      = $clog2(MAX_SLICES);
    localparam int DEV_W       = 8;
    localparam int ACC_W       = 2;
    localparam int MSEL_W      = 2;
    localparam int RSEL_W      = 4;
    localparam int ADDR_W      = 20;
    localparam int REGA_W      = 8;

    // field positions inside the address word
    localparam int DEV_LO      = 26;
    localparam int ACC_LO      = 24;
    localparam int MSEL_LO     = 22;
    localparam int IND_BIT     = 21;
    localparam int RSEL_LO     = 17;
    localparam int DM_A14_BIT  = 16;
    localparam int DUP_HI_BIT  = 15;
    localparam int DUP_LO_BIT  = 14;
    localparam int SRAM_HI_LO  = 16;
    localparam int SRAM_HI_W   = 5;

    typedef enum logic [2:0] {
        OP_LOOKUP   = 3'd0,
        OP_DM_RD    = 3'd1,
        OP_DM_WR    = 3'd2,
        OP_REG_RD   = 3'd3,
        OP_REG_WR   = 3'd4,
        OP_SRAM_RD  = 3'd5,
        OP_SRAM_WR  = 3'd6,
        OP_SRAM_NWR = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WID_72  = 2'd0,
        WID_144 = 2'd1,
        WID_288 = 2'd2,
        WID_RSV = 2'd3
    } wid_e;

    typedef struct packed {
        logic                 busy;
        logic                 in_addr;
        logic                 has_data;
        logic                 hold;
        logic [SIDX_W-1:0]    cnt;
        logic [SIDX_W-1:0]    last_cnt;
        logic [SIDX_W-1:0]    top;
        logic [SLICE_W-1:0]   addr_word;
        logic [PAYLOAD_W-1:0] payload;
    } seq_t;

    function automatic logic [SIDX_W-1:0] top_slice(input wid_e w);
        case (w)
            WID_144: return SIDX_W'(1);
            WID_288: return SIDX_W'(3);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sbreq_addr_fmt.sv
module sbreq_addr_fmt
    import sbreq_pkg::*;
(
    input  op_e                     op,
    input  logic [DEV_W-1:0]        dev_id,
    input  logic [ACC_W-1:0]        access,
    input  logic [MSEL_W-1:0]       mask_sel,
    input  logic                    indirect,
    input  logic [RSEL_W-1:0]       result_sel,
    input  logic [ADDR_W-1:0]       addr,
    output logic [SLICE_W-1:0]      word
);
    always_comb begin
        word = '0;
        word[DEV_LO +: DEV_W] = dev_id;
        word[ACC_LO +: ACC_W] = access;
        case (op)
            OP_DM_RD, OP_DM_WR: begin
                word[MSEL_LO +: MSEL_W] = mask_sel;
                word[IND_BIT]           = indirect;
                word[RSEL_LO +: RSEL_W] = result_sel;
                word[DM_A14_BIT]        = addr[14];
                word[DUP_HI_BIT]        = addr[13];
                word[DUP_LO_BIT:1]      = addr[13:0];
            end
            OP_REG_RD, OP_REG_WR: begin
                word[REGA_W-1:0]        = addr[REGA_W-1:0];
            end
            OP_SRAM_RD, OP_SRAM_WR, OP_SRAM_NWR: begin
                word[SRAM_HI_LO +: SRAM_HI_W] = addr[19:15];
                word[DUP_HI_BIT]        = addr[14];
                word[DUP_LO_BIT:0]      = addr[14:0];
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/sbreq_slicer.sv
module sbreq_slicer #(
    parameter int SW = 72,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [SW*N-1:0] payload,
    input  logic [IW-1:0]   sel,
    output logic [SW-1:0]   slice
);
    logic [SW-1:0] slices [N];

    for (genvar g = 0; g < N; g++) begin : g_cut
        assign slices[g] = payload[g*SW +: SW];
    end

    assign slice = slices[sel];
endmodule

// File: rtl/sbreq_serializer.sv
module sbreq_serializer
    import sbreq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [2:0]             cmd_op,
    input  logic [1:0]             cmd_width,
    input  logic [PAYLOAD_W-1:0]   cmd_payload,
    input  logic [DEV_W-1:0]       cmd_dev_id,
    input  logic [ACC_W-1:0]       cmd_access,
    input  logic [MSEL_W-1:0]      cmd_mask_sel,
    input  logic                   cmd_indirect,
    input  logic [RSEL_W-1:0]      cmd_result_sel,
    input  logic [ADDR_W-1:0]      cmd_addr,
    output logic [SLICE_W-1:0]     req_bus,
    output logic                   req_valid,
    output logic                   req_is_addr,
    output logic                   req_last,
    output logic [SIDX_W-1:0]      req_offset
);
    seq_t q, d;

    op_e                 op_in;
    wid_e                wid_in;
    logic [SLICE_W-1:0]  fmt_word;
    logic [SLICE_W-1:0]  cur_slice;
    logic [SIDX_W-1:0]   sidx;
    logic [SIDX_W-1:0]   top_in;
    logic                last_beat;
    logic                accept;

    assign op_in  = op_e'(cmd_op);
    assign wid_in = wid_e'(cmd_width);
    assign top_in = top_slice(wid_in);

    sbreq_addr_fmt u_fmt (
        .op         (op_in),
        .dev_id     (cmd_dev_id),
        .access     (cmd_access),
        .mask_sel   (cmd_mask_sel),
        .indirect   (cmd_indirect),
        .result_sel (cmd_result_sel),
        .addr       (cmd_addr),
        .word       (fmt_word)
    );

    sbreq_slicer #(.SW(SLICE_W), .N(MAX_SLICES)) u_slice (
        .payload (q.payload),
        .sel     (sidx),
        .slice   (cur_slice)
    );

    always_comb begin
        last_beat = q.busy && (q.in_addr ? !q.has_data : (q.cnt == q.last_cnt));
        cmd_ready = !q.busy || last_beat;
        accept    = cmd_valid && cmd_ready;
        sidx      = q.hold ? '0 : (q.top - q.cnt);

        req_valid   = q.busy;
        req_is_addr = q.busy && q.in_addr;
        req_last    = last_beat;
        req_offset  = (q.busy && !q.in_addr && !q.hold) ? q.cnt : '0;
        if (!q.busy)
            req_bus = '0;
        else if (q.in_addr)
            req_bus = q.addr_word;
        else
            req_bus = cur_slice;
    end

    always_comb begin
        d = q;
        if (accept) begin
            d.busy      = 1'b1;
            d.cnt       = '0;
            d.addr_word = fmt_word;
            d.payload   = cmd_payload;
            d.hold      = 1'b0;
            d.top       = '0;
            d.last_cnt  = '0;
            case (op_in)
                OP_LOOKUP: begin
                    d.in_addr  = 1'b0;
                    d.has_data = 1'b1;
                    d.top      = top_in;
                    d.hold     = (top_in == '0);
                    d.last_cnt = (top_in == '0) ? SIDX_W'(1) : top_in;
                end
                OP_DM_WR: begin
                    d.in_addr  = 1'b1;
                    d.has_data = 1'b1;
                    d.top      = top_in;
                    d.last_cnt = top_in;
                end
                OP_REG_WR, OP_SRAM_WR: begin
                    d.in_addr  = 1'b1;
                    d.has_data = 1'b1;
                end
                default: begin
                    d.in_addr  = 1'b1;
                    d.has_data = 1'b0;
                end
            endcase
        end else if (q.busy) begin
            if (last_beat) begin
                d = '0;
            end else if (q.in_addr) begin
                d.in_addr = 1'b0;
                d.cnt     = '0;
            end else begin
                d.cnt = q.cnt + SIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/sbreq_serializer_chk.sv
module sbreq_serializer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [71:0] req_bus,
    input logic        req_valid,
    input logic        req_is_addr,
    input logic        req_last
);
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (req_bus == '0));

    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_is_addr |-> (req_bus[71:34] == '0));

    p_dup_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_is_addr |-> (req_bus[15] == req_bus[14]));

    p_addr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_is_addr |-> req_valid);

    p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_last) |-> !cmd_ready);

    p_accept_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> req_valid);

    p_last_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_last && !cmd_valid) |=> !req_valid);
endmodule

bind sbreq_serializer sbreq_serializer_chk chk_i (.*);

// File: tb/sbreq_serializer_tb_top.sv
`timescale 1ns/1ps
module sbreq_serializer_tb_top;

    typedef struct {
        logic [71:0] bus;
        logic        is_addr;
        logic        last;
        logic [1:0]  off;
        string       tag;
    } beat_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_width = '0;
    logic [287:0] cmd_payload = '0;
    logic [7:0]   cmd_dev_id = '0;
    logic [1:0]   cmd_access = '0;
    logic [1:0]   cmd_mask_sel = '0;
    logic         cmd_indirect = 1'b0;
    logic [3:0]   cmd_result_sel = '0;
    logic [19:0]  cmd_addr = '0;
    logic [71:0]  req_bus;
    logic         req_valid;
    logic         req_is_addr;
    logic         req_last;
    logic [1:0]   req_offset;

    int n_checks = 0;
    int n_fail   = 0;
    int run_len  = 0;
    int last_run = 0;
    bit done     = 1'b0;
    beat_t exp_q[$];

    always #2.5 clk = ~clk;

    sbreq_serializer dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: pop one expected word per valid bus cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid) begin
                run_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected word", {4'b0, req_bus, req_is_addr, req_last, req_offset}, '0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(req_bus == e.bus && req_is_addr == e.is_addr && req_last == e.last && req_offset == e.off,
                          e.tag, {4'b0, req_bus, req_is_addr, req_last, req_offset},
                          {4'b0, e.bus, e.is_addr, e.last, e.off});
                end
            end else begin
                if (run_len != 0) last_run = run_len;
                run_len = 0;
            end
        end
    end

    function automatic logic [71:0] exp_addr(input int op, input logic [7:0] dev, input logic [1:0] acc,
                                             input logic [1:0] msk, input logic ind, input logic [3:0] res,
                                             input logic [19:0] a);
        if (op == 1 || op == 2)
            return {38'b0, dev, acc, msk, ind, res, a[14], a[13], a[13:0], 1'b0};
        else if (op == 3 || op == 4)
            return {38'b0, dev, acc, 16'b0, a[7:0]};
        else
            return {38'b0, dev, acc, 3'b0, a[19:15], a[14], a[14:0]};
    endfunction

    function automatic logic [287:0] pattern(input int seed);
        logic [287:0] p;
        for (int i = 0; i < 9; i++)
            p[i*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h01010101) ^ 32'hA5C3_0F1E;
        return p;
    endfunction

    task automatic push(input logic [71:0] b, input logic ia, input logic l, input logic [1:0] o, input string t);
        beat_t e;
        e.bus = b; e.is_addr = ia; e.last = l; e.off = o; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic push_slices(input logic [287:0] p, input logic [1:0] w, input string t);
        int n;
        n = (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
        for (int k = 0; k < n; k++)
            push(p[(n-1-k)*72 +: 72], 1'b0, k == n-1, 2'(k), t);
    endtask

    // driver: called at a negedge, returns at the negedge after acceptance
    task automatic send(input int op, input logic [1:0] w, input logic [287:0] p, input logic [7:0] dev,
                        input logic [1:0] acc, input logic [1:0] msk, input logic ind,
                        input logic [3:0] res, input logic [19:0] a, input string t);
        logic [71:0] aw;
        aw = exp_addr(op, dev, acc, msk, ind, res, a);
        if (op == 0) begin
            if (w == 2'd1 || w == 2'd2) push_slices(p, w, t);
            else begin
                push(p[71:0], 1'b0, 1'b0, 2'd0, t);
                push(p[71:0], 1'b0, 1'b1, 2'd0, t);
            end
        end else if (op == 2) begin
            push(aw, 1'b1, 1'b0, 2'd0, t);
            push_slices(p, w, t);
        end else if (op == 4 || op == 6) begin
            push(aw, 1'b1, 1'b0, 2'd0, t);
            push(p[71:0], 1'b0, 1'b1, 2'd0, t);
        end else begin
            push(aw, 1'b1, 1'b1, 2'd0, t);
        end
        cmd_op = 3'(op); cmd_width = w; cmd_payload = p; cmd_dev_id = dev; cmd_access = acc;
        cmd_mask_sel = msk; cmd_indirect = ind; cmd_result_sel = res; cmd_addr = a;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((exp_q.size() != 0 || req_valid) && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cmd_ready === 1'b1, "R1 ready after reset", {79'b0, cmd_ready}, 80'd1);
        check(req_valid === 1'b0, "R1 valid after reset", {79'b0, req_valid}, 80'd0);
        check(req_bus === '0, "R1 bus after reset", {8'b0, req_bus}, 80'd0);

        // R3: 72-bit lookup, held two cycles
        send(0, 2'd0, pattern(1), 8'h11, 2'd1, 2'd0, 1'b0, 4'h0, 20'h0, "R3 lookup72");
        drain();
        // R12: width code 3 behaves like 72
        send(0, 2'd3, pattern(2), 8'h00, 2'd0, 2'd0, 1'b0, 4'h0, 20'h0, "R12 width3 lookup");
        drain();
        // R4: 144 and 288 lookups, MS slice first
        send(0, 2'd1, pattern(3), 8'h00, 2'd0, 2'd0, 1'b0, 4'h0, 20'h0, "R4 lookup144");
        drain();
        send(0, 2'd2, pattern(4), 8'h00, 2'd0, 2'd0, 1'b0, 4'h0, 20'h0, "R4 lookup288");
        // R10: ready low until final word of the 288 lookup
        for (int k = 0; k < 4; k++) begin
            check(cmd_ready === (k == 3), "R10 ready during burst", {79'b0, cmd_ready}, {79'b0, k == 3});
            @(negedge clk);
        end
        drain();

        // R5 / R8: data/mask write, 288 bits
        send(2, 2'd2, pattern(5), 8'hA7, 2'd2, 2'd3, 1'b1, 4'h9, 20'h6ABCD, "R8 dm write288");
        drain();
        send(2, 2'd1, pattern(6), 8'h3C, 2'd1, 2'd1, 1'b0, 4'h6, 20'h02000, "R5 dm write144 a13");
        drain();
        // R5 / R9: data/mask read, single address word
        send(1, 2'd2, pattern(7), 8'h5A, 2'd3, 2'd2, 1'b1, 4'hF, 20'h05FFF, "R9 dm read");
        drain();
        // R6 / R9: register read and write
        send(3, 2'd0, pattern(8), 8'hC3, 2'd0, 2'd3, 1'b1, 4'hF, 20'hFFFA5, "R6 reg read");
        drain();
        send(4, 2'd2, pattern(9), 8'h81, 2'd2, 2'd0, 1'b0, 4'h0, 20'h0003C, "R6 reg write");
        drain();
        // R7 / R9: SRAM read, write, no-wait read
        send(5, 2'd0, pattern(10), 8'h42, 2'd1, 2'd3, 1'b1, 4'hA, 20'hF4321, "R7 sram read");
        drain();
        send(6, 2'd1, pattern(11), 8'h24, 2'd3, 2'd0, 1'b0, 4'h0, 20'h87FFF, "R7 sram write");
        drain();
        send(7, 2'd0, pattern(12), 8'hFF, 2'd2, 2'd0, 1'b0, 4'h0, 20'h0C000, "R7 sram nowait read");
        drain();

        // R10: back-to-back commands without a gap
        send(0, 2'd2, pattern(13), 8'h00, 2'd0, 2'd0, 1'b0, 4'h0, 20'h0, "R10 chain first");
        send(0, 2'd1, pattern(14), 8'h00, 2'd0, 2'd0, 1'b0, 4'h0, 20'h0, "R10 chain second");
        drain();
        check(last_run == 6, "R10 gap-free chain length", 80'(last_run), 80'd6);

        // R2: idle with changing inputs and no valid
        cmd_payload = pattern(99); cmd_addr = 20'hFFFFF; cmd_dev_id = 8'hFF; cmd_op = 3'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(req_valid === 1'b0 && req_bus === '0 && req_offset === '0 && req_last === 1'b0,
                  "R2 idle outputs", {6'b0, req_bus, req_valid, req_last}, 80'd0);
        end
        check(exp_q.size() == 0, "R11 all words seen", 80'(exp_q.size()), 80'd0);
        done = 1'b1;
        finish_run();
    end
endmodule